// File: doc/BRIEF.md
# Dual-Row Compute-in-Memory Bank

This block is a behavioural, synthesizable model of a scratchpad memory bank. Besides ordinary word writes and reads, it can activate two rows in the same access and return a function of the two stored words. The supported functions are AND, OR, NAND, NOR, XOR and a full-width sum. Two separate row decoders each drive a one-hot row vector, and the wordlines are the OR of the two. Each column turns the activated cells into two ideal sense outputs, "any cell holds 1" and "all cells hold 1". An operation decoder picks the reference and output-select controls that choose among these outputs.

XOR is not sensed directly. Each column forms it by NOR-ing the AND sense result with the NOR sense result. The sum reuses each column's AND and XOR with a carry rippling from bit 0 upward, so an add also takes a single access. A request is taken on one clock edge and its response is registered on that same edge, so it is visible for the following cycle.

The operation codes on `req_op` are: 0 READ, 1 NOT, 2 AND, 3 OR, 4 NAND, 5 NOR, 6 XOR, 7 ADD. READ and NOT use only row A. All other codes use rows A and B.

Top module: `cim_bank`

## Requirements
- R1: A request with `req_write`=1 stores `req_wdata` at row `req_addr_a` and produces no response (`rsp_valid` stays 0 in the following cycle).
- R2: READ (code 0) returns the word at row A on `rsp_data`, with `rsp_valid`=1, in the cycle after the request.
- R3: NOT (code 1) returns the bitwise complement of the word at row A.
- R4: AND (2), OR (3), NAND (4) and NOR (5) return that bitwise function of the words at rows A and B.
- R5: XOR (6) returns the bitwise exclusive-or of the words at rows A and B.
- R6: ADD (7) returns (A + B) mod 2^DATA_W, with carries propagating through every bit position.
- R7: For every two-row code with distinct addresses, `rsp_xor` carries A ^ B, whichever function was requested. For READ, NOT and error responses, `rsp_xor` is 0.
- R8: A two-row code whose two addresses are equal gives `rsp_valid`=1, `rsp_err`=1, `rsp_data`=0 and `rsp_xor`=0. READ and NOT never raise `rsp_err`.
- R9: READ and NOT ignore `req_addr_b`. A single-row access enables exactly one wordline, and a legal two-row access enables exactly two.
- R10: After reset, `rsp_valid`, `rsp_err`, `rsp_data` and `rsp_xor` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read/compute |
| req_op | input | 3 | Operation code (see R2 to R6) |
| req_addr_a | input | ADDR_W (4) | First row address |
| req_addr_b | input | ADDR_W (4) | Second row address |
| req_wdata | input | DATA_W (32) | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | Illegal operand (equal rows) |
| rsp_data | output | DATA_W (32) | Result word |
| rsp_xor | output | DATA_W (32) | Side output A ^ B |

## Verification
A wrong wordline decode, whether one row missing or one row extra, shows up as a corrupted result word in the cycle right after the request. The bench catches it by choosing operand pairs whose bits differ in every combination, and by pointing the unused address at data that differs from row A. A wrong reference or select setting in the operation decoder gives the function of another code. Every code is therefore run against the same operands, whose results all differ. A broken carry link only shows when a carry must travel far, so sums that ripple across all bit positions are included.

// File: rtl/cim_pkg.sv
package cim_pkg;
   typedef enum logic [2:0] {
      OP_READ = 3'd0,
      OP_NOT  = 3'd1,
      OP_AND  = 3'd2,
      OP_OR   = 3'd3,
      OP_NAND = 3'd4,
      OP_NOR  = 3'd5,
      OP_XOR  = 3'd6,
      OP_ADD  = 3'd7
   } cim_op_e;

   // reference enables for left/right sense stacks and output selects
   typedef struct packed {
      logic [2:0] ref_l;
      logic [2:0] ref_r;
      logic [2:0] sel;
      logic       dual;
   } cim_ctl_t;

   function automatic logic op_is_dual(input logic [2:0] op);
      return !(op == OP_READ || op == OP_NOT);
   endfunction
endpackage

// File: rtl/cim_row_decoder.sv
module cim_row_decoder #(
   parameter int ROWS   = 16,
   localparam int ADDR_W = $clog2(ROWS)
) (
   input  logic              en,
   input  logic [ADDR_W-1:0] addr,
   output logic [ROWS-1:0]   row_sel
);
   always_comb begin
      row_sel = '0;
      for (int r = 0; r < ROWS; r++)
         if (en && addr == ADDR_W'(r)) row_sel[r] = 1'b1;
   end
endmodule

// File: rtl/cim_op_decoder.sv
module cim_op_decoder
   import cim_pkg::*;
(
   input  logic [2:0] op,
   output cim_ctl_t   ctl
);
   always_comb begin
      ctl      = '0;
      ctl.dual = op_is_dual(op);
      unique case (cim_op_e'(op))
         OP_READ: begin ctl.ref_l = 3'b001; ctl.sel = 3'b011; end
         OP_NOT:  begin ctl.ref_r = 3'b001; ctl.sel = 3'b010; end
         OP_AND:  begin ctl.ref_l = 3'b101; ctl.sel = 3'b011; end
         OP_OR:   begin ctl.ref_l = 3'b011; ctl.sel = 3'b011; end
         OP_NAND: begin ctl.ref_r = 3'b101; ctl.sel = 3'b010; end
         OP_NOR:  begin ctl.ref_r = 3'b011; ctl.sel = 3'b010; end
         OP_XOR:  begin ctl.ref_l = 3'b011; ctl.ref_r = 3'b101; ctl.sel = 3'b100; end
         OP_ADD:  begin ctl.ref_l = 3'b011; ctl.ref_r = 3'b101; ctl.sel = 3'b000; end
         default: ctl = '0;
      endcase
   end
endmodule

// File: rtl/cim_column.sv
module cim_column (
   input  logic       any1,
   input  logic       all1,
   input  logic [2:0] ref_l,
   input  logic [2:0] ref_r,
   input  logic [2:0] sel,
   input  logic       cin,
   output logic       res,
   output logic       cout,
   output logic       xor_side
);
   logic pos_l, pos_r, col_xor, col_sum;

   // a high reference (bit 2 set) only passes when every enabled cell is 1
   assign pos_l    = ref_l[2] ? all1 : any1;
   assign pos_r    = ref_r[2] ? all1 : any1;
   assign col_xor  = ~(pos_r | ~pos_l);
   assign col_sum  = col_xor ^ cin;
   assign cout     = pos_r | (col_xor & cin);
   assign xor_side = ~(all1 | ~any1);

   always_comb begin
      if (sel[1])      res = sel[0] ? pos_l : ~pos_r;
      else if (sel[2]) res = col_xor;
      else             res = col_sum;
   end
endmodule

// File: rtl/cim_bank.sv
module cim_bank
   import cim_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ROWS   = 16,
   localparam int ADDR_W = $clog2(ROWS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [2:0]        req_op,
   input  logic [ADDR_W-1:0] req_addr_a,
   input  logic [ADDR_W-1:0] req_addr_b,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic              rsp_err,
   output logic [DATA_W-1:0] rsp_data,
   output logic [DATA_W-1:0] rsp_xor
);
   if (DATA_W < 1) begin : g_bad_w
      $error("cim_bank: DATA_W must be at least 1");
   end
   if (ROWS < 2) begin : g_bad_rows
      $error("cim_bank: ROWS must be at least 2");
   end

   logic [DATA_W-1:0] mem [ROWS];
   cim_ctl_t          ctl;
   logic              rd_req, bad_pair;
   logic [ROWS-1:0]   sel_a, sel_b, wl;
   logic [DATA_W-1:0] any1, all1, col_res, col_xs;
   logic [DATA_W:0]   carry;

   assign rd_req   = req_valid && !req_write;
   assign bad_pair = ctl.dual && (req_addr_a == req_addr_b);

   cim_op_decoder u_opdec (.op(req_op), .ctl(ctl));

   cim_row_decoder #(.ROWS(ROWS)) u_dec_a (
      .en(rd_req), .addr(req_addr_a), .row_sel(sel_a));
   cim_row_decoder #(.ROWS(ROWS)) u_dec_b (
      .en(rd_req && ctl.dual), .addr(req_addr_b), .row_sel(sel_b));

   assign wl = sel_a | sel_b;

   // ideal column sensing over the enabled rows
   always_comb begin
      any1 = '0;
      all1 = '1;
      for (int r = 0; r < ROWS; r++) begin
         if (wl[r]) begin
            any1 = any1 | mem[r];
            all1 = all1 & mem[r];
         end
      end
   end

   assign carry[0] = 1'b0;
   for (genvar c = 0; c < DATA_W; c++) begin : g_col
      cim_column u_col (
         .any1(any1[c]), .all1(all1[c]),
         .ref_l(ctl.ref_l), .ref_r(ctl.ref_r), .sel(ctl.sel),
         .cin(carry[c]), .res(col_res[c]), .cout(carry[c+1]),
         .xor_side(col_xs[c]));
   end

   always_ff @(posedge clk) begin
      if (req_valid && req_write) mem[req_addr_a] <= req_wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_data  <= '0;
         rsp_xor   <= '0;
      end else begin
         rsp_valid <= rd_req;
         rsp_err   <= rd_req && bad_pair;
         rsp_data  <= (rd_req && !bad_pair) ? col_res : '0;
         rsp_xor   <= (rd_req && ctl.dual && !bad_pair) ? col_xs : '0;
      end
   end
endmodule

// File: rtl/cim_bank_chk.sv
module cim_bank_chk #(
   parameter int DATA_W = 32,
   parameter int ROWS   = 16,
   localparam int ADDR_W = $clog2(ROWS)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_write,
   input logic [2:0]        req_op,
   input logic [ADDR_W-1:0] req_addr_a,
   input logic [ADDR_W-1:0] req_addr_b,
   input logic              rsp_valid,
   input logic              rsp_err,
   input logic [DATA_W-1:0] rsp_data,
   input logic [DATA_W-1:0] rsp_xor,
   input logic [ROWS-1:0]   wl
);
   logic dual_req;
   assign dual_req = !(req_op == 3'd0 || req_op == 3'd1);

   // R1
   write_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_write |=> !rsp_valid);
   // R2
   read_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_write |=> rsp_valid);
   // R5
   xor_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_write && req_op == 3'd6 && req_addr_a != req_addr_b
      |=> rsp_data == rsp_xor);
   // R8
   err_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_write && dual_req && req_addr_a == req_addr_b |=> rsp_err);
   // R8
   err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> rsp_valid && rsp_data == '0 && rsp_xor == '0);
   // R9
   one_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_write && !dual_req |-> $countones(wl) == 1);
   // R9
   two_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_write && dual_req && req_addr_a != req_addr_b
      |-> $countones(wl) == 2);
   // R9
   idle_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && !req_write) |-> wl == '0);
endmodule

bind cim_bank cim_bank_chk #(.DATA_W(DATA_W), .ROWS(ROWS)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
   .req_op(req_op), .req_addr_a(req_addr_a), .req_addr_b(req_addr_b),
   .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data),
   .rsp_xor(rsp_xor), .wl(wl));

// File: tb/test_cim_bank.sv
`timescale 1ns/1ps
module test_cim_bank;
   localparam int DW = 32;
   localparam int NR = 16;
   localparam int AW = $clog2(NR);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0, req_write = 1'b0;
   logic [2:0]    req_op = '0;
   logic [AW-1:0] req_addr_a = '0, req_addr_b = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          rsp_valid, rsp_err;
   logic [DW-1:0] rsp_data, rsp_xor;

   logic [DW-1:0] model [NR];
   int checks = 0, errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   cim_bank #(.DATA_W(DW), .ROWS(NR)) i_cim_bank (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_op(req_op), .req_addr_a(req_addr_a), .req_addr_b(req_addr_b),
      .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
      .rsp_data(rsp_data), .rsp_xor(rsp_xor));

   task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // drive at negedge; result is registered at the next posedge, sampled at the following negedge
   task automatic wr(input int a, input logic [DW-1:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr_a = AW'(a); req_wdata = d;
      model[a] = d;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
      check("R1 no response on write", {31'd0, rsp_valid}, '0);
   endtask

   task automatic op(input logic [2:0] code, input int a, input int b);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_op = code;
      req_addr_a = AW'(a); req_addr_b = AW'(b);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   function automatic logic [DW-1:0] expect_of(input logic [2:0] code, input int a, input int b);
      logic [DW-1:0] x = model[a], y = model[b];
      case (code)
         3'd0: return x;
         3'd1: return ~x;
         3'd2: return x & y;
         3'd3: return x | y;
         3'd4: return ~(x & y);
         3'd5: return ~(x | y);
         3'd6: return x ^ y;
         default: return x + y;
      endcase
   endfunction

   task automatic t_reset;
      check("R10 rsp_valid after reset", {31'd0, rsp_valid}, '0);
      check("R10 rsp_err after reset", {31'd0, rsp_err}, '0);
      check("R10 rsp_data after reset", rsp_data, '0);
      check("R10 rsp_xor after reset", rsp_xor, '0);
   endtask

   task automatic t_fill;
      wr(0, 32'hF0F0_A5A5);
      wr(1, 32'hFF00_3C3C);
      wr(2, 32'hFFFF_FFFF);
      wr(3, 32'h0000_0001);
      wr(4, 32'h8000_0000);
      wr(5, 32'h1234_5678);
   endtask

   task automatic t_single;
      op(3'd0, 0, 5);
      check("R2 READ valid", {31'd0, rsp_valid}, 1);
      check("R2 READ data", rsp_data, expect_of(3'd0, 0, 0));
      check("R7 READ side xor zero", rsp_xor, '0);
      op(3'd1, 1, 5);
      check("R3 NOT data", rsp_data, expect_of(3'd1, 1, 1));
      op(3'd0, 5, 5);
      check("R8 READ equal addresses no error", {31'd0, rsp_err}, 0);
      check("R9 READ ignores addr B", rsp_data, model[5]);
      op(3'd1, 3, 2);
      check("R9 NOT ignores addr B", rsp_data, ~model[3]);
   endtask

   task automatic t_logic;
      for (int k = 2; k <= 6; k++) begin
         op(3'(k), 0, 1);
         check($sformatf("R4/R5 op %0d data", k), rsp_data, expect_of(3'(k), 0, 1));
         check($sformatf("R7 op %0d side xor", k), rsp_xor, model[0] ^ model[1]);
      end
      op(3'd6, 5, 2);
      check("R5 XOR with all-ones", rsp_data, ~model[5]);
   endtask

   task automatic t_add;
      op(3'd7, 0, 1);
      check("R6 ADD mixed", rsp_data, model[0] + model[1]);
      check("R7 ADD side xor", rsp_xor, model[0] ^ model[1]);
      op(3'd7, 2, 3);
      check("R6 ADD full ripple wraps", rsp_data, 32'h0);
      op(3'd7, 4, 4 + 0);
      check("R8 ADD equal addresses err", {31'd0, rsp_err}, 1);
      op(3'd7, 4, 2);
      check("R6 ADD top bit", rsp_data, 32'h7FFF_FFFF);
   endtask

   task automatic t_err;
      op(3'd2, 1, 1);
      check("R8 AND equal err", {31'd0, rsp_err}, 1);
      check("R8 err valid", {31'd0, rsp_valid}, 1);
      check("R8 err data zero", rsp_data, '0);
      check("R8 err xor zero", rsp_xor, '0);
      op(3'd3, 0, 1);
      check("R8 err clears", {31'd0, rsp_err}, 0);
   endtask

   task automatic t_overwrite;
      wr(1, 32'h0F0F_0F0F);
      op(3'd0, 1, 0);
      check("R1 overwrite visible", rsp_data, 32'h0F0F_0F0F);
      op(3'd5, 1, 0);
      check("R4 NOR after overwrite", rsp_data, ~(model[1] | model[0]));
   endtask

   initial begin
      #1;
      t_reset();
      #9 rst_n = 1'b1;
      t_fill();
      t_single();
      t_logic();
      t_add();
      t_err();
      t_overwrite();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule